// File: doc/BRIEF.md
# Microinstruction Field Decoder

This block sits at the output of a microprogram control store. It takes the current 20-bit control word and splits it into its sections. There are three 3-bit micro-operation selectors, a 2-bit status-condition selector, a 2-bit branch-type selector and a 7-bit target address.

Each micro-operation selector has its own 3-to-8 decoder, so one control word can request up to three micro-operations at the same time. The all-zero code in a selector requests nothing.

From the decoded lines the block derives two groups of control signals:

- For the address register, a load enable and a source steer. The steer picks either the low eleven bits of the data register or the program counter.
- The function-select strobes for the arithmetic/logic unit.

The condition, branch and address sections go unchanged to the next-address sequencer. The whole block is combinational and has no state.

Top module: `uinst_field_decoder`

## Requirements
- R1: The control word is split MSB to LSB as op-select A [19:17], op-select B [16:14], op-select C [13:11], condition [10:9], branch [8:7] and address [6:0].
- R2: `opa_en_o` is one-hot with bit k set when op-select A equals k, for k = 1..7. It is all zero when op-select A is 000. Bit 0 is never set.
- R3: `opb_en_o` decodes op-select B by the same rule as R2.
- R4: `opc_en_o` decodes op-select C by the same rule as R2.
- R5: `ar_load_o` is 1 exactly when op-select A is 101 (low data-register bits to address register) or 110 (program counter to address register).
- R6: `ar_src_dr_o` is 1 (data-register bits 10:0) exactly when op-select A is 101. For every other code, including when no load is requested, it is 0, which selects the program counter.
- R7: `alu_add_o` is 1 exactly when op-select A is 001. `alu_xfer_o` is 1 exactly when op-select A is 100 (data register into accumulator). `alu_and_o` is 1 exactly when op-select B is 011.
- R8: `cond_o`, `br_o` and `addr_o` equal the condition, branch and address sections of the control word, unchanged.
- R9: The three op-select decoders are independent. Any combination of codes yields the three decodes at once, with no interaction between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| uinst_i | input | 20 | Current control word |
| opa_en_o | output | 8 | One-hot decode of op-select A |
| opb_en_o | output | 8 | One-hot decode of op-select B |
| opc_en_o | output | 8 | One-hot decode of op-select C |
| ar_load_o | output | 1 | Address register load enable |
| ar_src_dr_o | output | 1 | Address register source: 1 = DR[10:0], 0 = PC |
| alu_add_o | output | 1 | ALU add function select |
| alu_and_o | output | 1 | ALU logical AND function select |
| alu_xfer_o | output | 1 | ALU pass-through select (DR into AC) |
| cond_o | output | 2 | Condition section to sequencer |
| br_o | output | 2 | Branch-type section to sequencer |
| addr_o | output | 7 | Branch address section to sequencer |

## Verification
The block holds no state, so any fault shows up at the ports in the same cycle the control word is applied. A mis-wired slice of the control word shows as an enable line or a pass-through section that follows the wrong bits. A faulty decoder shows as a missing one-hot bit, a second set bit, or a bit set under the no-operation code. A faulty register-control term shows as an address-register load or steer for codes other than 101 and 110. The bench drives every joint value of the three op-selects, together with walking and extreme values of the sequencer sections. As a result each such fault is caught on the first control word that exposes it.

// File: rtl/uinst_pkg.sv
package uinst_pkg;
  localparam int unsigned OP_W   = 3;
  localparam int unsigned COND_W = 2;
  localparam int unsigned BR_W   = 2;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned N_OPS  = 3;
  localparam int unsigned UI_W   = N_OPS * OP_W + COND_W + BR_W + ADDR_W;
  localparam int unsigned EN_W   = 1 << OP_W;

  // op-select A codes used by derived controls
  localparam logic [OP_W-1:0] A_ADD   = 3'd1;
  localparam logic [OP_W-1:0] A_DR2AC = 3'd4;
  localparam logic [OP_W-1:0] A_DR2AR = 3'd5;
  localparam logic [OP_W-1:0] A_PC2AR = 3'd6;
  // op-select B codes used by derived controls
  localparam logic [OP_W-1:0] B_AND   = 3'd3;

  typedef struct packed {
    logic [OP_W-1:0]   opa;
    logic [OP_W-1:0]   opb;
    logic [OP_W-1:0]   opc;
    logic [COND_W-1:0] cond;
    logic [BR_W-1:0]   br;
    logic [ADDR_W-1:0] addr;
  } uinst_t;
endpackage

// File: rtl/op_field_dec.sv
module op_field_dec
  import uinst_pkg::*;
(
  input  logic [OP_W-1:0] code_i,
  output logic [EN_W-1:0] en_o
);
  // code 0 is a no-op: its line is held low
  assign en_o[0] = 1'b0;

  for (genvar gi = 1; gi < EN_W; gi++) begin : g_line
    assign en_o[gi] = (code_i == OP_W'(gi));
  end

  always_comb begin
    if (code_i == '0) AST_NOP_SILENT: assert (en_o == '0);       // R2
    if (code_i != '0) AST_ONE_LINE: assert ($countones(en_o) == 1); // R2
  end
endmodule

// File: rtl/ar_ctrl.sv
module ar_ctrl (
  input  logic dr2ar_i,
  input  logic pc2ar_i,
  output logic load_o,
  output logic src_dr_o
);
  assign load_o   = dr2ar_i | pc2ar_i;
  assign src_dr_o = dr2ar_i;   // PC path whenever DR path not requested

  always_comb begin
    if (src_dr_o) AST_SRC_NEEDS_LOAD: assert (load_o); // R6
  end
endmodule

// File: rtl/alu_sel.sv
module alu_sel (
  input  logic add_i,
  input  logic and_i,
  input  logic xfer_i,
  output logic add_o,
  output logic and_o,
  output logic xfer_o
);
  assign add_o  = add_i;
  assign and_o  = and_i;
  assign xfer_o = xfer_i;
endmodule

// File: rtl/uinst_field_decoder.sv
module uinst_field_decoder
  import uinst_pkg::*;
(
  input  logic [UI_W-1:0]   uinst_i,
  output logic [EN_W-1:0]   opa_en_o,
  output logic [EN_W-1:0]   opb_en_o,
  output logic [EN_W-1:0]   opc_en_o,
  output logic              ar_load_o,
  output logic              ar_src_dr_o,
  output logic              alu_add_o,
  output logic              alu_and_o,
  output logic              alu_xfer_o,
  output logic [COND_W-1:0] cond_o,
  output logic [BR_W-1:0]   br_o,
  output logic [ADDR_W-1:0] addr_o
);
  uinst_t ui;
  assign ui = uinst_t'(uinst_i);

  logic [N_OPS-1:0][OP_W-1:0] codes;
  logic [N_OPS-1:0][EN_W-1:0] ens;
  assign codes = {ui.opa, ui.opb, ui.opc};

  for (genvar gf = 0; gf < N_OPS; gf++) begin : g_dec
    op_field_dec i_dec (
      .code_i(codes[gf]),
      .en_o  (ens[gf])
    );
  end

  assign opa_en_o = ens[2];
  assign opb_en_o = ens[1];
  assign opc_en_o = ens[0];

  ar_ctrl i_ar_ctrl (
    .dr2ar_i (opa_en_o[A_DR2AR]),
    .pc2ar_i (opa_en_o[A_PC2AR]),
    .load_o  (ar_load_o),
    .src_dr_o(ar_src_dr_o)
  );

  alu_sel i_alu_sel (
    .add_i (opa_en_o[A_ADD]),
    .and_i (opb_en_o[B_AND]),
    .xfer_i(opa_en_o[A_DR2AC]),
    .add_o (alu_add_o),
    .and_o (alu_and_o),
    .xfer_o(alu_xfer_o)
  );

  assign cond_o = ui.cond;
  assign br_o   = ui.br;
  assign addr_o = ui.addr;

  always_comb begin
    if (ar_load_o) AST_AR_LOAD_CODE: assert (uinst_i[19:17] == 3'd5 || uinst_i[19:17] == 3'd6); // R5
    AST_ALU_A_EXCL: assert ($onehot0({alu_add_o, alu_xfer_o, ar_load_o}));                       // R7
    AST_SEQ_PASS: assert ({cond_o, br_o, addr_o} == uinst_i[10:0]);                              // R8
  end
endmodule

// File: tb/test_uinst_field_decoder.sv
module test_uinst_field_decoder;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [19:0] uinst = '0;
  logic [7:0]  opa_en, opb_en, opc_en;
  logic        ar_load, ar_src_dr, alu_add, alu_and, alu_xfer;
  logic [1:0]  cond, br;
  logic [6:0]  addr;

  uinst_field_decoder i_uinst_field_decoder (
    .uinst_i(uinst), .opa_en_o(opa_en), .opb_en_o(opb_en), .opc_en_o(opc_en),
    .ar_load_o(ar_load), .ar_src_dr_o(ar_src_dr), .alu_add_o(alu_add),
    .alu_and_o(alu_and), .alu_xfer_o(alu_xfer), .cond_o(cond), .br_o(br), .addr_o(addr)
  );

  typedef struct packed {
    logic [7:0] a, b, c;
    logic       ld, src, add, andf, xfer;
    logic [10:0] seq;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  function automatic logic [7:0] dec(input logic [2:0] f);
    return (f == 3'd0) ? 8'h00 : (8'h01 << f);
  endfunction

  task automatic drive(input logic [2:0] a, b, c, input logic [1:0] cd, bq, input logic [6:0] ad);
    exp_t e;
    e.a = dec(a); e.b = dec(b); e.c = dec(c);
    e.ld = (a == 3'd5) || (a == 3'd6);
    e.src = (a == 3'd5);
    e.add = (a == 3'd1);
    e.xfer = (a == 3'd4);
    e.andf = (b == 3'd3);
    e.seq = {cd, bq, ad};
    @(posedge clk);
    uinst = {a, b, c, cd, bq, ad};  // R1 field order
    q.push_back(e);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: uinst=%05h act=%0h exp=%0h", req, uinst, act, exp);
    end
  endtask

  // monitor: compare at falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R2", 32'(opa_en), 32'(e.a));
      chk("R3", 32'(opb_en), 32'(e.b));
      chk("R4", 32'(opc_en), 32'(e.c));
      chk("R5", 32'(ar_load), 32'(e.ld));
      chk("R6", 32'(ar_src_dr), 32'(e.src));
      chk("R7", 32'({alu_add, alu_and, alu_xfer}), 32'({e.add, e.andf, e.xfer}));
      chk("R8", 32'({cond, br, addr}), 32'(e.seq));
    end
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // reset-like idle word: all no-op, PC steer (R6)
    drive(3'd0, 3'd0, 3'd0, 2'd0, 2'd0, 7'd0);
    // R9 exhaustive joint codes, R1 with varied sequencer sections
    for (int i = 0; i < 512; i++)
      drive(3'(i >> 6), 3'(i >> 3), 3'(i), 2'(i), 2'(i >> 2), 7'(i * 37));
    // R8 walking ones and extremes across sequencer sections
    for (int k = 0; k < 11; k++) begin
      logic [10:0] w;
      w = 11'(1) << k;
      drive(3'd0, 3'd0, 3'd0, w[10:9], w[8:7], w[6:0]);
    end
    drive(3'd7, 3'd7, 3'd7, 2'd3, 2'd3, 7'h7f);
    drive(3'd5, 3'd3, 3'd0, 2'd0, 2'd0, 7'h00);  // R5 R6 R7 DR path with AND
    drive(3'd6, 3'd0, 3'd0, 2'd1, 2'd2, 7'h40);  // R5 R6 PC path
    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule